// File: doc/BRIEF.md
# Barrel Thread Scheduler

This block is the control loop of a fine-grain multithreaded core. Up to `DEPTH` thread contexts, each carried as a 32-bit status word, ride a ring of `DEPTH` registers. The ring advances one slot every cycle. The slot at the head is the only one that may offer an instruction: if it holds a live context, the block presents that context's status word on the issue port. After the head, the word re-enters at the tail of the ring. A modelled execution pipeline of the same depth later returns the next program counter for it. Because the two loops move in lock step, a context comes round exactly once every `DEPTH` cycles and can never run ahead of its own previous instruction.

Contexts are added through a spawn port and removed through a kill strobe. A killed context is marked halted wherever it sits in the ring. It is dropped when it next reaches the head, and that slot can be refilled in the same cycle. Empty slots circulate as bubbles, and nothing is offered in the cycles where a bubble is at the head.

Back-pressure works as follows. The issue offer is valid/ready, but a refused offer is withdrawn, not held. The context moves on with its PC unchanged and is offered again `DEPTH` cycles later. The spawn port is valid/ready in the usual sense: the source holds `spawn_valid` and its fields until the handshake. The result port has no ready, and a result must arrive in its fixed cycle.

Top module: `barrel_sched`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `issue_valid` is 0 and `spawn_ready` is 1, with every ring slot empty.
- R2: `spawn_ready` is 1 exactly when the head slot is empty or holds a halted context. A spawn is accepted in a cycle where `spawn_valid` and `spawn_ready` are both 1, and that context is first offered `DEPTH` cycles later. The source keeps `spawn_valid` high until acceptance.
- R3: The offered word packs bit 31 valid (1), bit 30 user flag (from spawn), bit 29 branched flag, bit 28 halt flag (0 when offered), bits 27:24 thread ID and bits 23:0 PC. `issue_valid` is 1 whenever the head holds a live context.
- R4: Two successive offers of the same context are exactly `DEPTH` cycles apart. With `DEPTH` live contexts, an offer is made every cycle.
- R5: In a cycle where the head slot is empty, `issue_valid` is 0.
- R6: An offer taken by the `issue_ready` handshake expects its result `DEPTH-1` cycles later, tagged with the same thread ID. The next offer's PC is `result_target` if `result_taken` is 1, else PC+1 modulo 2^24. The branched flag takes the value of `result_taken`.
- R7: If the expected result does not arrive, the context is offered again with the same PC and flags.
- R8: An offer refused with `issue_ready` low expects no result. It returns `DEPTH` cycles later with the same PC.
- R9: After a `kill_valid` pulse naming a live thread, that thread is never offered again, even if its result lands in the same cycle. In the cycle its slot reaches the head, `issue_valid` is 0 and `spawn_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | output | 1 | Head slot offers a live context |
| issue_ready | input | 1 | Consumer takes the offer this cycle |
| issue_psw | output | 32 | Status word of the offered context |
| result_valid | input | 1 | Next-PC result from the execution loop |
| result_tid | input | 4 | Thread the result belongs to |
| result_taken | input | 1 | Result is a taken branch |
| result_target | input | 24 | Branch target PC |
| spawn_valid | input | 1 | New context requested |
| spawn_ready | output | 1 | Head slot free for insertion |
| spawn_tid | input | 4 | Thread ID of new context |
| spawn_pc | input | 24 | Start PC of new context |
| spawn_user | input | 1 | User flag of new context |
| kill_valid | input | 1 | Remove a context |
| kill_tid | input | 4 | Thread ID to remove |

## Verification
The sharpest collisions are a removal landing in the same cycle as that thread's next-PC result, and a spawn landing in the cycle where a halted context is retired at the head. The bench waits until the result due from its execution-loop model belongs to the victim thread, and pulses the kill in exactly that cycle. It then holds a spawn request pending so that it is accepted in the retirement cycle. A reference model built from the requirements predicts, for every cycle, whether an offer appears, whether the head is free, and the full offered word. It also predicts that the victim never reappears and that the newcomer is first offered one loop later.

// File: rtl/barrel_pkg.sv
`timescale 1ns/1ps
package barrel_pkg;
  localparam int PC_W  = 24;
  localparam int TID_W = 4;
  localparam int PSW_W = 4 + TID_W + PC_W;
  localparam int NTID  = 1 << TID_W;

  typedef struct packed {
    logic             valid;
    logic             user;
    logic             branched;
    logic             halt;
    logic [TID_W-1:0] tid;
    logic [PC_W-1:0]  pc;
  } psw_t;

  typedef struct packed {
    logic pend;   // offer taken, result still owed
    psw_t psw;
  } slot_t;
endpackage

// File: rtl/barrel_kill_mark.sv
`timescale 1ns/1ps
module barrel_kill_mark
  import barrel_pkg::*;
(
  input  slot_t            in_slot,
  input  logic             kill_valid,
  input  logic [TID_W-1:0] kill_tid,
  output slot_t            out_slot
);
  always_comb begin
    out_slot = in_slot;
    if (kill_valid && in_slot.psw.valid && (in_slot.psw.tid == kill_tid))
      out_slot.psw.halt = 1'b1;
  end
endmodule

// File: rtl/barrel_result_merge.sv
`timescale 1ns/1ps
module barrel_result_merge
  import barrel_pkg::*;
(
  input  slot_t           tail_slot,
  input  logic            result_valid,
  input  logic            result_taken,
  input  logic [PC_W-1:0] result_target,
  output slot_t           merged
);
  always_comb begin
    merged = tail_slot;
    if (tail_slot.pend) begin
      merged.pend = 1'b0;
      if (result_valid) begin
        merged.psw.pc       = result_taken ? result_target
                                           : tail_slot.psw.pc + PC_W'(1);
        merged.psw.branched = result_taken;
      end
    end
  end
endmodule

// File: rtl/barrel_head_ctl.sv
`timescale 1ns/1ps
module barrel_head_ctl
  import barrel_pkg::*;
(
  input  slot_t            head_slot,
  input  logic             issue_ready,
  input  logic             spawn_valid,
  input  logic [TID_W-1:0] spawn_tid,
  input  logic [PC_W-1:0]  spawn_pc,
  input  logic             spawn_user,
  output logic             issue_valid,
  output psw_t             issue_word,
  output logic             spawn_ready,
  output slot_t            reenter_slot
);
  logic retire;
  logic fire;

  assign retire      = head_slot.psw.valid & head_slot.psw.halt;
  assign issue_valid = head_slot.psw.valid & ~head_slot.psw.halt;
  assign spawn_ready = ~head_slot.psw.valid | head_slot.psw.halt;
  assign fire        = issue_valid & issue_ready;
  assign issue_word  = head_slot.psw;

  always_comb begin
    reenter_slot = head_slot;
    if (spawn_valid && spawn_ready) begin
      reenter_slot              = '0;
      reenter_slot.psw.valid    = 1'b1;
      reenter_slot.psw.user     = spawn_user;
      reenter_slot.psw.tid      = spawn_tid;
      reenter_slot.psw.pc       = spawn_pc;
    end else if (retire) begin
      reenter_slot = '0;
    end else if (fire) begin
      reenter_slot.pend = 1'b1;
    end
  end
endmodule

// File: rtl/barrel_sched.sv
`timescale 1ns/1ps
module barrel_sched
  import barrel_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             issue_valid,
  input  logic             issue_ready,
  output logic [PSW_W-1:0] issue_psw,
  input  logic             result_valid,
  input  logic [TID_W-1:0] result_tid,
  input  logic             result_taken,
  input  logic [PC_W-1:0]  result_target,
  input  logic             spawn_valid,
  output logic             spawn_ready,
  input  logic [TID_W-1:0] spawn_tid,
  input  logic [PC_W-1:0]  spawn_pc,
  input  logic             spawn_user,
  input  logic             kill_valid,
  input  logic [TID_W-1:0] kill_tid
);
  localparam int GAP_W = $clog2(DEPTH) + 1;

  slot_t ring   [DEPTH];
  slot_t nxt    [DEPTH];
  slot_t marked [DEPTH];
  slot_t merged;
  slot_t reenter;
  psw_t  issue_word;

  barrel_head_ctl u_head (
    .head_slot   (ring[0]),
    .issue_ready (issue_ready),
    .spawn_valid (spawn_valid),
    .spawn_tid   (spawn_tid),
    .spawn_pc    (spawn_pc),
    .spawn_user  (spawn_user),
    .issue_valid (issue_valid),
    .issue_word  (issue_word),
    .spawn_ready (spawn_ready),
    .reenter_slot(reenter)
  );

  // The word about to become head picks up its next PC here.
  barrel_result_merge u_merge (
    .tail_slot    (ring[1]),
    .result_valid (result_valid),
    .result_taken (result_taken),
    .result_target(result_target),
    .merged       (merged)
  );

  assign issue_psw = issue_word;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == DEPTH - 1) begin : g_tail
      assign nxt[i] = reenter;
    end else if (i == 0) begin : g_head
      assign nxt[i] = merged;
    end else begin : g_mid
      assign nxt[i] = ring[i+1];
    end

    barrel_kill_mark u_kill (
      .in_slot   (nxt[i]),
      .kill_valid(kill_valid),
      .kill_tid  (kill_tid),
      .out_slot  (marked[i])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ring[i] <= '0;
      else        ring[i] <= marked[i];
    end
  end

  // Results arrive only for the word owing one, and only for its thread.
  assert_result_aligned_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (ring[1].pend && ring[1].psw.valid && ring[1].psw.tid == result_tid));

  // A word reaching the head has settled its previous result.
  assert_head_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    issue_valid |-> !ring[0].pend);

  // A refused offer goes round with no result owed.
  assert_refused_no_debt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_ready) |=> !ring[DEPTH-1].pend);

  // A halted head leaves an empty tail slot unless refilled.
  assert_retire_frees_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ring[0].psw.valid && ring[0].psw.halt && !spawn_valid) |=> !ring[DEPTH-1].psw.valid);

  // Spawn source holds its request until taken.
  assert_spawn_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (spawn_valid && !spawn_ready) |=> spawn_valid);

  // Strict rotation: per-thread spacing between offers, counted, not unrolled.
  logic [GAP_W-1:0] gap_q [NTID];
  logic [NTID-1:0]  seen_q;

  for (genvar k = 0; k < NTID; k++) begin : g_gap
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gap_q[k]  <= '0;
        seen_q[k] <= 1'b0;
      end else if (issue_valid && issue_word.tid == TID_W'(k)) begin
        gap_q[k]  <= '0;
        seen_q[k] <= 1'b1;
      end else if (gap_q[k] < GAP_W'(DEPTH)) begin
        gap_q[k]  <= gap_q[k] + GAP_W'(1);
      end
    end

    assert_rotation_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_valid && issue_word.tid == TID_W'(k) && seen_q[k]) |-> (gap_q[k] >= GAP_W'(DEPTH - 1)));
  end
endmodule

// File: tb/tb_barrel_sched.sv
`timescale 1ns/1ps
module tb_barrel_sched;
  import barrel_pkg::*;
  localparam int D = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic issue_valid, issue_ready, spawn_ready;
  logic [PSW_W-1:0] issue_psw;
  logic result_valid, result_taken, spawn_valid, spawn_user, kill_valid;
  logic [TID_W-1:0] result_tid, spawn_tid, kill_tid;
  logic [PC_W-1:0]  result_target, spawn_pc;

  always #2.5 clk = ~clk;

  barrel_sched #(.DEPTH(D)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_psw(issue_psw), .result_valid(result_valid), .result_tid(result_tid),
    .result_taken(result_taken), .result_target(result_target), .spawn_valid(spawn_valid),
    .spawn_ready(spawn_ready), .spawn_tid(spawn_tid), .spawn_pc(spawn_pc),
    .spawn_user(spawn_user), .kill_valid(kill_valid), .kill_tid(kill_tid)
  );

  // spawn vectors: {tid, user, start pc}; the pc 24'hFFFFFE checks wrap
  localparam logic [28:0] SPAWN_TAB [6] = '{
    {4'd0, 1'b0, 24'h000010}, {4'd1, 1'b1, 24'h000103}, {4'd2, 1'b0, 24'h000222},
    {4'd3, 1'b1, 24'h00ABC1}, {4'd4, 1'b0, 24'hFFFFFE}, {4'd5, 1'b1, 24'h000005}
  };

  int tests = 0, fails = 0, cyc = 0, offers = 0;
  bit done = 0;
  string tag_pc = "R6";

  bit            present [NTID];
  bit            halted  [NTID];
  int            last_seen [NTID];
  logic [23:0]   exp_pc  [NTID];
  bit            exp_br  [NTID];
  bit            usr     [NTID];
  bit            pv   [D-1];
  logic [3:0]    ptid [D-1];
  logic [23:0]   ppc  [D-1];

  bit want_spawn = 0, want_kill = 0, ready_req = 1, accepted = 0;
  logic [3:0] sp_tid = '0, k_tid = '0;
  logic [23:0] sp_pc = '0;
  bit sp_user = 0;
  int drop_tid = -1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic tick();
    int due;
    bit hs, taken;
    logic [23:0] tgt;
    @(negedge clk);
    cyc++;
    due = -1;
    for (int t = 0; t < NTID; t++)
      if (present[t] && last_seen[t] + D == cyc) due = t;
    if (due >= 0 && halted[due]) begin
      chk(issue_valid == 1'b0, "R9", "offer from removed thread", issue_valid, 0);
      chk(spawn_ready == 1'b1, "R9", "slot free at removal", spawn_ready, 1);
      present[due] = 0;
    end else if (due >= 0) begin
      chk(issue_valid == 1'b1, "R4", "offer on rotation", issue_valid, 1);
      chk(spawn_ready == 1'b0, "R2", "head busy", spawn_ready, 0);
      if (issue_valid) begin
        chk(issue_psw[27:24] == due[3:0], "R3", "tid", issue_psw[27:24], due);
        chk(issue_psw[23:0] == exp_pc[due], tag_pc, "pc", issue_psw[23:0], exp_pc[due]);
        chk(issue_psw[31] == 1'b1 && issue_psw[28] == 1'b0, "R3", "valid/halt bits",
            issue_psw[31:28], 4'h8);
        chk(issue_psw[30] == usr[due], "R3", "user flag", issue_psw[30], usr[due]);
        chk(issue_psw[29] == exp_br[due], "R6", "branched flag", issue_psw[29], exp_br[due]);
      end
      last_seen[due] = cyc;
    end else begin
      chk(issue_valid == 1'b0, "R5", "bubble", issue_valid, 0);
      chk(spawn_ready == 1'b1, "R2", "head free", spawn_ready, 1);
    end
    if (issue_valid) offers++;

    hs = issue_valid && ready_req;
    issue_ready = ready_req;
    // execution loop model: result due D-1 cycles after handshake
    result_valid = 1'b0; result_tid = '0; result_taken = 1'b0; result_target = '0;
    if (pv[D-2]) begin
      if (drop_tid == int'(ptid[D-2])) begin
        drop_tid = -1;
      end else begin
        taken = (ppc[D-2][1:0] == 2'b11);
        tgt = ppc[D-2] + 24'd100;
        result_valid = 1'b1; result_tid = ptid[D-2];
        result_taken = taken; result_target = tgt;
        exp_pc[ptid[D-2]] = taken ? tgt : ppc[D-2] + 24'd1;
        exp_br[ptid[D-2]] = taken;
      end
    end
    for (int j = D - 2; j > 0; j--) begin
      pv[j] = pv[j-1]; ptid[j] = ptid[j-1]; ppc[j] = ppc[j-1];
    end
    pv[0] = hs; ptid[0] = issue_psw[27:24]; ppc[0] = issue_psw[23:0];

    spawn_valid = want_spawn; spawn_tid = sp_tid; spawn_pc = sp_pc; spawn_user = sp_user;
    accepted = 0;
    if (want_spawn && spawn_ready) begin
      present[sp_tid] = 1; halted[sp_tid] = 0; last_seen[sp_tid] = cyc;
      exp_pc[sp_tid] = sp_pc; usr[sp_tid] = sp_user; exp_br[sp_tid] = 0;
      want_spawn = 0; accepted = 1;
    end
    kill_valid = want_kill; kill_tid = k_tid;
    if (want_kill && present[k_tid]) halted[k_tid] = 1;
    want_kill = 0;
  endtask

  task automatic spawn_one(input logic [3:0] t, input bit u, input logic [23:0] pc);
    sp_tid = t; sp_user = u; sp_pc = pc; want_spawn = 1;
    for (int n = 0; n < 4 * D && want_spawn; n++) tick();
    chk(want_spawn == 0, "R2", "spawn accepted", want_spawn, 0);
    want_spawn = 0;
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int kill_cyc, bcount;
    issue_ready = 1; result_valid = 0; result_tid = '0; result_taken = 0;
    result_target = '0; spawn_valid = 0; spawn_tid = '0; spawn_pc = '0;
    spawn_user = 0; kill_valid = 0; kill_tid = '0;
    for (int t = 0; t < NTID; t++) begin
      present[t] = 0; halted[t] = 0; last_seen[t] = 0; exp_pc[t] = '0;
      exp_br[t] = 0; usr[t] = 0;
    end
    for (int j = 0; j < D - 1; j++) begin pv[j] = 0; ptid[j] = '0; ppc[j] = '0; end

    repeat (3) @(negedge clk);
    chk(issue_valid == 0, "R1", "issue_valid in reset", issue_valid, 0);
    chk(spawn_ready == 1, "R1", "spawn_ready in reset", spawn_ready, 1);
    rst_n = 1'b1;
    tick();  // first cycle out of reset: model expects empty ring (R1)

    // vector table: six contexts, two bubbles left in the loop (R5)
    for (int v = 0; v < 6; v++)
      spawn_one(SPAWN_TAB[v][28:25], SPAWN_TAB[v][24], SPAWN_TAB[v][23:0]);
    offers = 0;
    repeat (5 * D) tick();
    chk(offers == 30, "R5", "offers over five loops with six contexts", offers, 30);

    // full ring: an offer every cycle (R4)
    spawn_one(4'd6, 1'b0, 24'h000300);
    spawn_one(4'd7, 1'b1, 24'h000403);
    repeat (D) tick();
    offers = 0;
    repeat (4 * D) tick();
    chk(offers == 4 * D, "R4", "offers with full ring", offers, 4 * D);

    // back-pressure (R8)
    tag_pc = "R8";
    ready_req = 0;
    repeat (5) tick();
    ready_req = 1;
    repeat (3 * D) tick();

    // missing result (R7)
    tag_pc = "R7";
    drop_tid = 3;
    repeat (3 * D) tick();
    chk(drop_tid == -1, "R7", "result withheld once", drop_tid, -1);
    tag_pc = "R6";

    // kill in the cycle its result lands, then refill the freed slot (R9)
    for (int n = 0; n < 4 * D && !(pv[D-2] && ptid[D-2] == 4'd2); n++) tick();
    k_tid = 4'd2; want_kill = 1;
    tick();
    kill_cyc = cyc;
    sp_tid = 4'd9; sp_user = 1'b1; sp_pc = 24'h000500; want_spawn = 1;
    bcount = 0;
    for (int n = 0; n < 2 * D && want_spawn; n++) begin tick(); bcount++; end
    chk(accepted == 1 && bcount <= D, "R9", "freed slot reused within a loop", bcount, D);
    chk(present[2] == 0, "R9", "killed thread dropped", present[2], 0);
    repeat (4 * D) tick();
    chk(cyc > kill_cyc, "R9", "run continued", cyc, kill_cyc + 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule